// File: doc/BRIEF.md
# Device Status Register

This block holds the 8-bit device status byte that a host reads to learn why a device needs attention. A 4-bit status code reports the latest status event. Beside it sit a flag for bootloader (flash-programming) mode and a flag that shows the device has lost its configuration. Event pulses come from elsewhere in the chip, such as self-check engines and fault detectors. The host clears the reset condition by writing a "configured" control bit through a write strobe.

The code is driven by a three-state machine:

- `ST_RESET_HELD`: code 1.
- `ST_CLEAN`: code 0.
- `ST_FAULT`: the code of the last event is held.

It has four named transitions:

- `T_EV_FROM_RESET`: `ST_RESET_HELD` to `ST_FAULT` on any event.
- `T_CONFIGURE`: `ST_RESET_HELD` to `ST_CLEAN` on a configured write.
- `T_EV_FROM_CLEAN`: `ST_CLEAN` to `ST_FAULT` on any event.
- `T_EV_REPLACE`: `ST_FAULT` to `ST_FAULT` with a new code on any event.

When several events arrive in the same cycle, a fixed-priority encoder picks one. A one-cycle interrupt request marks each change of the byte from zero to non-zero.

Top module: `dev_status_reg`

## Requirements
- R1: While `rst_ni` is low the byte reads 0x81: code 1, bit 7 (unconfigured) 1, bit 6 0. `irq_o` stays low while reset is held.
- R2: Bits 3:0 hold the code, bits 5:4 read 0, bit 6 is the flash-programming flag and bit 7 is the unconfigured flag. The code is always one of 0 to 6.
- R3: The event bits map to codes as follows: `event_i[0]` CRC in progress gives 6, `[1]` invalid configuration gives 2, `[2]` configuration CRC failure gives 4, `[3]` firmware CRC failure gives 5 and `[4]` device failure gives 3. The code is updated at the clock edge that samples the pulse.
- R4: When several event bits are set in one cycle, the highest set bit wins. The order is bit 4, then 3, then 2, then 1, then 0.
- R5: An event code stays in place until another event arrives. A configured write does not clear it.
- R6: After reset the code stays 1 until an event arrives or a write with `cfg_wr_i`=1 and `cfg_set_i`=1 is made. That write turns code 1 into 0.
- R7: A write with `cfg_set_i`=1 clears bit 7, and bit 7 stays clear until the next reset. A write with `cfg_set_i`=0 changes nothing in the byte.
- R8: When an event and a configured write arrive in the same cycle, the event's code is stored and bit 7 is cleared.
- R9: With `HAS_FLASH`=1, bit 6 equals `boot_mode_i` as sampled at the previous edge. With `HAS_FLASH`=0, bit 6 always reads 0.
- R10: `irq_o` is high for exactly one cycle, at the edge where the byte goes from zero to non-zero, and also at the first edge after reset release. It does not fire again while the byte stays non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| event_i | input | 5 | Status event pulses, one bit per condition |
| boot_mode_i | input | 1 | High while the device runs in bootloader mode |
| cfg_wr_i | input | 1 | Host write strobe for the configured control bit |
| cfg_set_i | input | 1 | Value written to the configured bit |
| status_o | output | 8 | Status byte as read by the host |
| irq_o | output | 1 | One-cycle device-status interrupt request |

## Verification
The bench builds two copies of the block side by side, one with `HAS_FLASH`=1 and one with `HAS_FLASH`=0, and drives both with the same stimulus. The copy with flash support makes the byte become non-zero through the mode flag alone. That exercises the interrupt edge while the code and the unconfigured flag are both clear. The copy without flash support shows that bit 6 stays 0 under that same stimulus and that no interrupt fires from it.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int STATUS_BYTE_W = 8;
    localparam int STATUS_CODE_W = 4;
    localparam int EVT_NUM       = 5;
    localparam int EVT_IDX_W     = $clog2(EVT_NUM);
    localparam int RSVD_W        = STATUS_BYTE_W - STATUS_CODE_W - 2;

    // event bit positions; a higher position has higher priority
    localparam int EVT_CRC_BUSY = 0;
    localparam int EVT_BAD_CFG  = 1;
    localparam int EVT_CFG_CRC  = 2;
    localparam int EVT_FW_CRC   = 3;
    localparam int EVT_DEV_FAIL = 4;

    typedef enum logic [STATUS_CODE_W-1:0] {
        CODE_OK       = 4'd0,
        CODE_RESET    = 4'd1,
        CODE_BAD_CFG  = 4'd2,
        CODE_DEV_FAIL = 4'd3,
        CODE_CFG_CRC  = 4'd4,
        CODE_FW_CRC   = 4'd5,
        CODE_CRC_BUSY = 4'd6
    } code_e;

    typedef enum logic [1:0] {
        ST_RESET_HELD = 2'd0,
        ST_CLEAN      = 2'd1,
        ST_FAULT      = 2'd2
    } fsm_e;

    function automatic code_e evt_to_code(input logic [EVT_IDX_W-1:0] idx);
        code_e c;
        unique case (int'(idx))
            EVT_CRC_BUSY: c = CODE_CRC_BUSY;
            EVT_BAD_CFG:  c = CODE_BAD_CFG;
            EVT_CFG_CRC:  c = CODE_CFG_CRC;
            EVT_FW_CRC:   c = CODE_FW_CRC;
            EVT_DEV_FAIL: c = CODE_DEV_FAIL;
            default:      c = CODE_OK;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dsr_evt_arb.sv
module dsr_evt_arb #(
    parameter int N_SRC = 5,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] win_o
);

    // ascending scan: the last set bit seen, the highest index, wins
    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                win_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dsr_code_fsm.sv
module dsr_code_fsm
    import dsr_pkg::*;
(
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     evt_any_i,
    input  code_e                    evt_code_i,
    input  logic                     configure_i,
    output logic [STATUS_CODE_W-1:0] code_d_o,
    output logic [STATUS_CODE_W-1:0] code_q_o
);

    fsm_e  state_q, state_d;
    code_e held_q, held_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RESET_HELD;
            held_q  <= CODE_OK;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            ST_RESET_HELD: begin
                if (evt_any_i) begin          // T_EV_FROM_RESET
                    state_d = ST_FAULT;
                    held_d  = evt_code_i;
                end else if (configure_i) begin // T_CONFIGURE
                    state_d = ST_CLEAN;
                end
            end
            ST_CLEAN: begin
                if (evt_any_i) begin          // T_EV_FROM_CLEAN
                    state_d = ST_FAULT;
                    held_d  = evt_code_i;
                end
            end
            ST_FAULT: begin
                if (evt_any_i) begin          // T_EV_REPLACE
                    held_d = evt_code_i;
                end
            end
            default: begin
                state_d = ST_RESET_HELD;
                held_d  = CODE_OK;
            end
        endcase
    end

    // outputs: present and next code
    always_comb begin
        unique case (state_q)
            ST_RESET_HELD: code_q_o = CODE_RESET;
            ST_CLEAN:      code_q_o = CODE_OK;
            ST_FAULT:      code_q_o = held_q;
            default:       code_q_o = CODE_RESET;
        endcase
        unique case (state_d)
            ST_RESET_HELD: code_d_o = CODE_RESET;
            ST_CLEAN:      code_d_o = CODE_OK;
            ST_FAULT:      code_d_o = held_d;
            default:       code_d_o = CODE_RESET;
        endcase
    end

endmodule

// File: rtl/dsr_rise_pulse.sv
module dsr_rise_pulse #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] val_d_i,
    output logic         pulse_o
);

    logic seen_q;
    logic pulse_q;
    logic nz_d;

    assign nz_d = |val_d_i;

    // seen_q starts at zero, so the non-zero reset value counts as a rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            seen_q  <= nz_d;
            pulse_q <= nz_d & ~seen_q;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/dev_status_reg.sv
module dev_status_reg
    import dsr_pkg::*;
#(
    parameter bit HAS_FLASH = 1'b1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [EVT_NUM-1:0]       event_i,
    input  logic                     boot_mode_i,
    input  logic                     cfg_wr_i,
    input  logic                     cfg_set_i,
    output logic [STATUS_BYTE_W-1:0] status_o,
    output logic                     irq_o
);

    logic                     evt_any;
    logic [EVT_IDX_W-1:0]     evt_win;
    code_e                    evt_code;
    logic                     configure;
    logic [STATUS_CODE_W-1:0] code_d, code_q;
    logic                     unconf_q, unconf_d;
    logic                     flash_q, flash_d;
    logic [STATUS_BYTE_W-1:0] byte_d;

    assign configure = cfg_wr_i & cfg_set_i;

    dsr_evt_arb #(
        .N_SRC (EVT_NUM),
        .IDX_W (EVT_IDX_W)
    ) u_arb (
        .req_i (event_i),
        .any_o (evt_any),
        .win_o (evt_win)
    );

    assign evt_code = evt_to_code(evt_win);

    dsr_code_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .evt_any_i   (evt_any),
        .evt_code_i  (evt_code),
        .configure_i (configure),
        .code_d_o    (code_d),
        .code_q_o    (code_q)
    );

    assign unconf_d = configure ? 1'b0 : unconf_q;

    generate
        if (HAS_FLASH) begin : g_flash
            assign flash_d = boot_mode_i;
        end else begin : g_no_flash
            assign flash_d = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            unconf_q <= 1'b1;
            flash_q  <= 1'b0;
        end else begin
            unconf_q <= unconf_d;
            flash_q  <= flash_d;
        end
    end

    assign byte_d   = {unconf_d, flash_d, {RSVD_W{1'b0}}, code_d};
    assign status_o = {unconf_q, flash_q, {RSVD_W{1'b0}}, code_q};

    dsr_rise_pulse #(
        .W (STATUS_BYTE_W)
    ) u_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .val_d_i (byte_d),
        .pulse_o (irq_o)
    );

endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
    parameter bit HAS_FLASH = 1'b1
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [4:0] event_i,
    input logic       boot_mode_i,
    input logic       cfg_wr_i,
    input logic       cfg_set_i,
    input logic [7:0] status_o,
    input logic       irq_o
);

    assert_code_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o[3:0] <= 4'd6);

    assert_crc_busy_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_i == 5'b00001) |=> (status_o[3:0] == 4'd6));

    assert_top_priority_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_i[4] |=> (status_o[3:0] == 4'd3));

    assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[3:0] > 4'd1 && event_i == 5'b0) |=> $stable(status_o[3:0]));

    assert_reset_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[3:0] == 4'd1 && event_i == 5'b0 && !(cfg_wr_i && cfg_set_i))
        |=> (status_o[3:0] == 4'd1));

    assert_unconf_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_i && cfg_set_i) |=> !status_o[7]);

    assert_unconf_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !status_o[7] |=> !status_o[7]);

    assert_same_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_i == 5'b00010 && cfg_wr_i && cfg_set_i)
        |=> (status_o[3:0] == 4'd2 && !status_o[7]));

    assert_flash_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (status_o[6] == (HAS_FLASH && $past(boot_mode_i))));

    assert_irq_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

    assert_irq_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (status_o != 8'd0));

endmodule

bind dev_status_reg dsr_checker #(.HAS_FLASH(HAS_FLASH)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .event_i     (event_i),
    .boot_mode_i (boot_mode_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_set_i   (cfg_set_i),
    .status_o    (status_o),
    .irq_o       (irq_o)
);

// File: tb/dev_status_reg_tb.sv
`timescale 1ns/1ps
module dev_status_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ev = '0;
    logic       bm = 1'b0;
    logic       wr = 1'b0;
    logic       st = 1'b0;
    logic [7:0] stat_f, stat_n;
    logic       irq_f, irq_n;

    int n_checks = 0;
    int n_errs   = 0;

    always #4 clk = ~clk;   // 125 MHz

    dev_status_reg #(.HAS_FLASH(1'b1)) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .event_i (ev), .boot_mode_i (bm),
        .cfg_wr_i (wr), .cfg_set_i (st), .status_o (stat_f), .irq_o (irq_f));

    dev_status_reg #(.HAS_FLASH(1'b0)) u_dut_nf (
        .clk_i (clk), .rst_ni (rst_n), .event_i (ev), .boot_mode_i (bm),
        .cfg_wr_i (wr), .cfg_set_i (st), .status_o (stat_n), .irq_o (irq_n));

    // reference model: index 0 = with flash, 1 = without
    int m_code;
    bit m_unc;
    bit m_fl[2];
    bit m_seen[2];
    bit m_irq[2];

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_code = 1;
        m_unc  = 1'b1;
        for (int k = 0; k < 2; k++) begin
            m_fl[k] = 1'b0; m_seen[k] = 1'b0; m_irq[k] = 1'b0;
        end
    endtask

    task automatic model_step(input logic [4:0] e, input logic b, input logic w, input logic s);
        // R3 R4: highest set bit decides the code
        if (e[4])      m_code = 3;
        else if (e[3]) m_code = 5;
        else if (e[2]) m_code = 4;
        else if (e[1]) m_code = 2;
        else if (e[0]) m_code = 6;
        else if (w && s && m_code == 1) m_code = 0;   // R6
        if (w && s) m_unc = 1'b0;                      // R7 R8
        for (int k = 0; k < 2; k++) begin
            bit nz;
            m_fl[k] = (k == 0) ? b : 1'b0;             // R9
            nz = (m_code != 0) || m_unc || m_fl[k];
            m_irq[k] = nz && !m_seen[k];               // R10
            m_seen[k] = nz;
        end
    endtask

    task automatic check_all(input bit in_rst);
        logic [7:0] s;
        logic       q;
        for (int k = 0; k < 2; k++) begin
            s = (k == 0) ? stat_f : stat_n;
            q = (k == 0) ? irq_f : irq_n;
            if (in_rst) begin
                chk("R1 reset byte", int'(s), 8'h81);
                chk("R1 reset irq", int'(q), 0);
            end else begin
                chk("R3 R4 R5 R6 R8 code", int'(s[3:0]), m_code);
                chk("R2 reserved bits", int'(s[5:4]), 0);
                chk("R9 flash flag", int'(s[6]), int'(m_fl[k]));
                chk("R7 unconfigured flag", int'(s[7]), int'(m_unc));
                chk("R10 irq", int'(q), int'(m_irq[k]));
            end
        end
    endtask

    task automatic cyc(input logic [4:0] e, input logic b, input logic w, input logic s);
        @(negedge clk);
        check_all(1'b0);
        ev = e; bm = b; wr = w; st = s;
        model_step(e, b, w, s);
    endtask

    task automatic do_reset();
        @(negedge clk);
        if (rst_n) check_all(1'b0);
        rst_n = 1'b0;
        ev = '0; bm = 1'b0; wr = 1'b0; st = 1'b0;
        model_reset();
        repeat (3) begin
            @(negedge clk);
            check_all(1'b1);                 // R1
        end
        rst_n = 1'b1;
        model_step(5'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        // R6: reset code held while idle; R7: write with set=0 has no effect
        repeat (3) cyc(5'b0, 1'b0, 1'b0, 1'b0);
        cyc(5'b0, 1'b0, 1'b1, 1'b0);
        cyc(5'b0, 1'b0, 1'b0, 1'b0);
        // R6 R7: configured write clears code and flag, byte becomes zero
        cyc(5'b0, 1'b0, 1'b1, 1'b1);
        cyc(5'b0, 1'b0, 1'b0, 1'b0);
        // R9 R10: mode flag alone makes byte non-zero
        cyc(5'b0, 1'b1, 1'b0, 1'b0);
        cyc(5'b0, 1'b1, 1'b0, 1'b0);
        cyc(5'b0, 1'b0, 1'b0, 1'b0);
        cyc(5'b0, 1'b1, 1'b0, 1'b0);
        cyc(5'b0, 1'b0, 1'b0, 1'b0);
        // R3: each event alone; R5 sticky through a configured write
        for (int i = 0; i < 5; i++) begin
            cyc(5'(1 << i), 1'b0, 1'b0, 1'b0);
            cyc(5'b0, 1'b0, 1'b1, 1'b1);
            cyc(5'b0, 1'b0, 1'b0, 1'b0);
        end
        // R4: combined events
        cyc(5'b11111, 1'b0, 1'b0, 1'b0);
        cyc(5'b01111, 1'b0, 1'b0, 1'b0);
        cyc(5'b00111, 1'b0, 1'b0, 1'b0);
        cyc(5'b00011, 1'b0, 1'b0, 1'b0);
        cyc(5'b10001, 1'b0, 1'b0, 1'b0);
        cyc(5'b0, 1'b0, 1'b0, 1'b0);
        // R8: event and configured write together straight after reset
        do_reset();
        cyc(5'b0, 1'b0, 1'b0, 1'b0);
        cyc(5'b00010, 1'b0, 1'b1, 1'b1);
        cyc(5'b0, 1'b0, 1'b0, 1'b0);
        // R6: event from reset state replaces code 1
        do_reset();
        cyc(5'b00100, 1'b1, 1'b0, 1'b0);
        cyc(5'b0, 1'b1, 1'b0, 1'b0);
        cyc(5'b0, 1'b0, 1'b1, 1'b1);
        cyc(5'b0, 1'b0, 1'b0, 1'b0);
        // mixed traffic
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] e;
            if (n % 700 == 699) do_reset();
            e = (($urandom % 10) == 0) ? 5'($urandom) : 5'b0;
            cyc(e, ($urandom % 16) == 0 ? ~bm : bm,
                ($urandom % 6) == 0, $urandom % 2);
        end
        cyc(5'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check_all(1'b0);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule